// File: doc/BRIEF.md
# PCM DAC Serial Output Interface

This block takes decoded stereo PCM sample pairs and shifts them out to an external audio DAC as a serial stream. It makes its own master clock, bit clock and word-select from the system clock. Each frame carries one left and one right 16-bit word, sent MSB first. The master clock runs at 256 or 384 times the sample rate, and a static select input picks which.

A host-facing control set covers four things: word-select polarity, a user mute, a mute triggered by decode errors, and a 3-bit decoder mode. Muting is soft. A per-frame gain moves toward zero in fixed steps and climbs back the same way on release, which avoids an audible click. One mode code hands all four serial pins to an external bypass port.

Top module: `pcm_dac_serializer`

## Requirements
- R1: Serial data changes only on a falling edge of the output bit clock. Each channel slot is SLOT_W (32) bit clocks long and a frame is two slots. The 16-bit word occupies slot positions 1 to 16, MSB first, so it starts one bit clock after the word-select change. Every other slot position carries 0.
- R2: Each bit-clock period holds exactly 4 master-clock periods when `sel_384_i` is 0 (master clock at 256 times the sample rate). It holds 6 when `sel_384_i` is 1 (384 times).
- R3: Word-select changes only on a falling edge of the bit clock.
  - With `ws_invert_i` at 0, word-select is 1 during the left slot and 0 during the right slot.
  - With `ws_invert_i` at 1, the sense is reversed.
- R4: While `rst` is high, all four serial outputs and `mute_status_o` are 0, and the gain is at full scale.
- R5: While `user_mute_i` is 1, the gain falls by GAIN_STEP once per frame, down to 0. After release it rises by GAIN_STEP per frame, up to full scale (2^GAIN_W). Each sent word equals floor(sample * gain / 2^GAIN_W).
- R6: With `err_mute_en_i` at 1, a high `dec_error_i` mutes the output exactly as the user mute does. With `err_mute_en_i` at 0, `dec_error_i` has no effect on the output.
- R7: `mute_status_o` is 1 exactly while the gain of the frame being sent is below full scale.
- R8: When `dec_mode_i` equals 3'b110, each of the four serial outputs copies its bypass input one clock later. Any other mode code gives the internal outputs.
- R9: The gain changes only at the start of a left slot, so both words of a frame use the same gain.
- R10: The pair captured on the last `pcm_valid_i` strobe before a frame starts is the pair that frame sends. At full gain it is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pcm_left_i | input | SAMPLE_W | Left sample, two's complement |
| pcm_right_i | input | SAMPLE_W | Right sample, two's complement |
| pcm_valid_i | input | 1 | Captures the sample pair |
| sel_384_i | input | 1 | Master clock 384x (1) or 256x (0) the sample rate |
| ws_invert_i | input | 1 | Reverse word-select polarity |
| user_mute_i | input | 1 | Host soft-mute request |
| err_mute_en_i | input | 1 | Allow decode errors to mute |
| dec_error_i | input | 1 | Bitstream or decoder error indication |
| dec_mode_i | input | 3 | Decoder mode; 3'b110 selects bypass |
| byp_sd_i | input | 1 | Bypass serial data |
| byp_bclk_i | input | 1 | Bypass bit clock |
| byp_ws_i | input | 1 | Bypass word-select |
| byp_mclk_i | input | 1 | Bypass master clock |
| dac_sd_o | output | 1 | Serial data to DAC |
| dac_bclk_o | output | 1 | Bit clock to DAC |
| dac_ws_o | output | 1 | Word-select to DAC |
| dac_mclk_o | output | 1 | Master clock to DAC |
| mute_status_o | output | 1 | Soft mute active (gain below full) |

## Verification
The bench uses MCLK_HALF=1, which makes the master clock half the system clock. That gives frames of 512 or 768 system clocks, so about a hundred whole frames fit in one run. GAIN_W=8 with GAIN_STEP=32 gives a full ramp of eight frames. Each of the nine gain levels then maps to a distinct word for a near-full-scale sample, so every decoded frame shows exactly which gain it used. The bench decodes the stream at the pins, tracks the ramp down to zero and back, and checks both master-clock ratios, both polarities and the bypass hand-over.

// File: rtl/pcm_ser_pkg.sv
package pcm_ser_pkg;
  localparam logic [2:0] MODE_BYPASS = 3'b110;
  localparam int unsigned MCLK_PER_BCLK_256 = 4;
  localparam int unsigned MCLK_PER_BCLK_384 = 6;

  typedef struct packed {
    logic sd;
    logic bclk;
    logic ws;
    logic mclk;
  } ser_pins_t;
endpackage

// File: rtl/pcm_clk_div.sv
module pcm_clk_div #(
  parameter int unsigned MCLK_HALF = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_384_i,
  output logic mclk_o,
  output logic bclk_o,
  output logic bclk_fall_o
);
  import pcm_ser_pkg::*;

  localparam int unsigned CW = (MCLK_HALF > 1) ? $clog2(MCLK_HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(MCLK_HALF - 1);
  // bit-clock half period counted in master-clock toggles
  localparam logic [2:0] EDGE_LAST_256 = 3'(MCLK_PER_BCLK_256 - 1);
  localparam logic [2:0] EDGE_LAST_384 = 3'(MCLK_PER_BCLK_384 - 1);

  logic [CW-1:0] cnt_q;
  logic [2:0]    edge_q;
  logic [2:0]    edge_last;
  logic          half_wrap;

  assign edge_last   = sel_384_i ? EDGE_LAST_384 : EDGE_LAST_256;
  assign half_wrap   = (cnt_q == CNT_LAST) && (edge_q >= edge_last);
  assign bclk_fall_o = half_wrap && bclk_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      edge_q <= '0;
      mclk_o <= 1'b0;
      bclk_o <= 1'b0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q  <= '0;
      mclk_o <= ~mclk_o;
      if (edge_q >= edge_last) begin
        edge_q <= '0;
        bclk_o <= ~bclk_o;
      end else begin
        edge_q <= edge_q + 3'd1;
      end
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/pcm_gain_ramp.sv
module pcm_gain_ramp #(
  parameter int unsigned GAIN_W    = 8,
  parameter int unsigned GAIN_STEP = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_tick_i,
  input  logic              mute_req_i,
  output logic [GAIN_W:0]   gain_o,
  output logic [GAIN_W:0]   gain_next_o,
  output logic              muted_o
);
  localparam logic [GAIN_W:0] FULL_V = (GAIN_W+1)'(1) << GAIN_W;
  localparam logic [GAIN_W:0] STEP_V = (GAIN_W+1)'(GAIN_STEP);

  always_comb begin
    if (mute_req_i)
      gain_next_o = (gain_o > STEP_V) ? (gain_o - STEP_V) : '0;
    else
      gain_next_o = (gain_o < (FULL_V - STEP_V)) ? (gain_o + STEP_V) : FULL_V;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_o  <= FULL_V;
      muted_o <= 1'b0;
    end else if (frame_tick_i) begin
      gain_o  <= gain_next_o;
      muted_o <= (gain_next_o != FULL_V);
    end
  end
endmodule

// File: rtl/pcm_scale.sv
module pcm_scale #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned GAIN_W   = 8
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [GAIN_W:0]     gain_i,
  output logic [SAMPLE_W-1:0] scaled_o
);
  localparam int unsigned PW = SAMPLE_W + GAIN_W + 2;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shifted;

  always_comb begin
    prod     = PW'($signed(sample_i)) * PW'($signed({1'b0, gain_i}));
    shifted  = prod >>> GAIN_W;
    scaled_o = shifted[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/pcm_frame_ser.sv
module pcm_frame_ser #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned SLOT_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk_fall_i,
  input  logic                invert_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                frame_start_o,
  output logic                sd_o,
  output logic                ws_o
);
  localparam int unsigned PW = $clog2(2 * SLOT_W);
  localparam logic [PW-1:0] POS_LAST = PW'(2 * SLOT_W - 1);

  logic [PW-1:0]       pos_q;
  logic [PW-1:0]       pos_n;
  logic [PW-2:0]       in_slot;
  logic                right_slot;
  logic [SAMPLE_W-1:0] shreg_q;
  logic [SAMPLE_W-1:0] right_hold_q;

  assign pos_n         = (pos_q == POS_LAST) ? '0 : pos_q + PW'(1);
  assign in_slot       = pos_n[PW-2:0];
  assign right_slot    = pos_n[PW-1];
  assign frame_start_o = bclk_fall_i && (pos_q == POS_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q        <= POS_LAST;
      shreg_q      <= '0;
      right_hold_q <= '0;
      sd_o         <= 1'b0;
      ws_o         <= 1'b0;
    end else if (bclk_fall_i) begin
      pos_q <= pos_n;
      ws_o  <= ~right_slot ^ invert_i;
      if (in_slot == '0) begin
        sd_o    <= 1'b0;
        shreg_q <= right_slot ? right_hold_q : left_i;
        if (!right_slot)
          right_hold_q <= right_i;
      end else begin
        sd_o    <= shreg_q[SAMPLE_W-1];
        shreg_q <= {shreg_q[SAMPLE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/pcm_dac_serializer.sv
module pcm_dac_serializer #(
  parameter int unsigned SAMPLE_W  = 16,
  parameter int unsigned SLOT_W    = 32,
  parameter int unsigned GAIN_W    = 8,
  parameter int unsigned GAIN_STEP = 32,
  parameter int unsigned MCLK_HALF = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] pcm_left_i,
  input  logic [SAMPLE_W-1:0] pcm_right_i,
  input  logic                pcm_valid_i,
  input  logic                sel_384_i,
  input  logic                ws_invert_i,
  input  logic                user_mute_i,
  input  logic                err_mute_en_i,
  input  logic                dec_error_i,
  input  logic [2:0]          dec_mode_i,
  input  logic                byp_sd_i,
  input  logic                byp_bclk_i,
  input  logic                byp_ws_i,
  input  logic                byp_mclk_i,
  output logic                dac_sd_o,
  output logic                dac_bclk_o,
  output logic                dac_ws_o,
  output logic                dac_mclk_o,
  output logic                mute_status_o
);
  import pcm_ser_pkg::*;

  localparam int unsigned NCH = 2;

  logic [SAMPLE_W-1:0] pend_q   [NCH];
  logic [SAMPLE_W-1:0] scaled   [NCH];
  logic [SAMPLE_W-1:0] pcm_in   [NCH];
  logic [GAIN_W:0]     gain_q;
  logic [GAIN_W:0]     gain_next;
  logic                mute_req;
  logic                frame_start;
  logic                int_mclk, int_bclk, bclk_fall, int_sd, int_ws;
  ser_pins_t           int_pins, byp_pins, out_q;

  assign pcm_in[0] = pcm_left_i;
  assign pcm_in[1] = pcm_right_i;
  assign mute_req  = user_mute_i | (err_mute_en_i & dec_error_i);

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      always_ff @(posedge clk) begin
        if (rst)
          pend_q[ch] <= '0;
        else if (pcm_valid_i)
          pend_q[ch] <= pcm_in[ch];
      end

      pcm_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_scale (
        .sample_i (pend_q[ch]),
        .gain_i   (gain_next),
        .scaled_o (scaled[ch])
      );
    end
  endgenerate

  pcm_clk_div #(.MCLK_HALF(MCLK_HALF)) u_clk (
    .clk         (clk),
    .rst         (rst),
    .sel_384_i   (sel_384_i),
    .mclk_o      (int_mclk),
    .bclk_o      (int_bclk),
    .bclk_fall_o (bclk_fall)
  );

  pcm_gain_ramp #(.GAIN_W(GAIN_W), .GAIN_STEP(GAIN_STEP)) u_gain (
    .clk          (clk),
    .rst          (rst),
    .frame_tick_i (frame_start),
    .mute_req_i   (mute_req),
    .gain_o       (gain_q),
    .gain_next_o  (gain_next),
    .muted_o      (mute_status_o)
  );

  pcm_frame_ser #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_ser (
    .clk           (clk),
    .rst           (rst),
    .bclk_fall_i   (bclk_fall),
    .invert_i      (ws_invert_i),
    .left_i        (scaled[0]),
    .right_i       (scaled[1]),
    .frame_start_o (frame_start),
    .sd_o          (int_sd),
    .ws_o          (int_ws)
  );

  // internal bit clock register falls in the same cycle the serializer updates
  assign int_pins = '{sd: int_sd, bclk: int_bclk, ws: int_ws, mclk: int_mclk};
  assign byp_pins = '{sd: byp_sd_i, bclk: byp_bclk_i, ws: byp_ws_i, mclk: byp_mclk_i};

  always_ff @(posedge clk) begin
    if (rst)
      out_q <= '0;
    else if (dec_mode_i == MODE_BYPASS)
      out_q <= byp_pins;
    else
      out_q <= int_pins;
  end

  assign dac_sd_o   = out_q.sd;
  assign dac_bclk_o = out_q.bclk;
  assign dac_ws_o   = out_q.ws;
  assign dac_mclk_o = out_q.mclk;
endmodule

// File: rtl/pcm_ser_chk.sv
module pcm_ser_chk #(
  parameter int unsigned GAIN_W    = 8,
  parameter int unsigned GAIN_STEP = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      mode_i,
  input logic            byp_sd_i,
  input logic            byp_bclk_i,
  input logic            byp_ws_i,
  input logic            byp_mclk_i,
  input logic            sd_o,
  input logic            bclk_o,
  input logic            ws_o,
  input logic            mclk_o,
  input logic            status_o,
  input logic [GAIN_W:0] gain_i,
  input logic            frame_start_i
);
  import pcm_ser_pkg::*;

  localparam int FULL = 1 << GAIN_W;

  p_bypass_pins_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_BYPASS) |=> (sd_o == $past(byp_sd_i) && bclk_o == $past(byp_bclk_i) &&
                                 ws_o == $past(byp_ws_i) && mclk_o == $past(byp_mclk_i)));

  p_sd_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
    (mode_i != MODE_BYPASS && $past(mode_i) != MODE_BYPASS && $past(mode_i, 2) != MODE_BYPASS
     && !$stable(sd_o)) |-> $fell(bclk_o));

  p_ws_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_i != MODE_BYPASS && $past(mode_i) != MODE_BYPASS && $past(mode_i, 2) != MODE_BYPASS
     && !$stable(ws_o)) |-> $fell(bclk_o));

  p_gain_step_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(gain_i) |-> (int'(gain_i) == int'($past(gain_i)) - int'(GAIN_STEP) ||
                          int'(gain_i) == int'($past(gain_i)) + int'(GAIN_STEP) ||
                          int'(gain_i) == 0 || int'(gain_i) == FULL));

  p_gain_range_r5: assert property (@(posedge clk) disable iff (rst)
    int'(gain_i) <= FULL);

  p_gain_at_frame_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(gain_i) |-> $past(frame_start_i));

  p_status_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(status_o) |-> $past(frame_start_i));
endmodule

bind pcm_dac_serializer pcm_ser_chk #(.GAIN_W(GAIN_W), .GAIN_STEP(GAIN_STEP)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_i        (dec_mode_i),
  .byp_sd_i      (byp_sd_i),
  .byp_bclk_i    (byp_bclk_i),
  .byp_ws_i      (byp_ws_i),
  .byp_mclk_i    (byp_mclk_i),
  .sd_o          (dac_sd_o),
  .bclk_o        (dac_bclk_o),
  .ws_o          (dac_ws_o),
  .mclk_o        (dac_mclk_o),
  .status_o      (mute_status_o),
  .gain_i        (gain_q),
  .frame_start_i (frame_start)
);

// File: tb/test_pcm_dac_serializer.sv
module test_pcm_dac_serializer;
  localparam int GW    = 8;
  localparam int STEP  = 32;
  localparam int FULL  = 1 << GW;
  localparam int NSTEP = FULL / STEP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] pcm_l = '0, pcm_r = '0;
  logic pcm_v = 1'b0, sel384 = 1'b0, inv = 1'b0, umute = 1'b0, emen = 1'b0, derr = 1'b0;
  logic [2:0] mode = 3'b000;
  logic bsd = 1'b0, bbclk = 1'b0, bws = 1'b0, bmclk = 1'b0;
  logic o_sd, o_bclk, o_ws, o_mclk, o_stat;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  pcm_dac_serializer #(.SAMPLE_W(16), .SLOT_W(32), .GAIN_W(GW), .GAIN_STEP(STEP), .MCLK_HALF(1))
  i_pcm_dac_serializer (
    .clk(clk), .rst(rst), .pcm_left_i(pcm_l), .pcm_right_i(pcm_r), .pcm_valid_i(pcm_v),
    .sel_384_i(sel384), .ws_invert_i(inv), .user_mute_i(umute), .err_mute_en_i(emen),
    .dec_error_i(derr), .dec_mode_i(mode), .byp_sd_i(bsd), .byp_bclk_i(bbclk),
    .byp_ws_i(bws), .byp_mclk_i(bmclk), .dac_sd_o(o_sd), .dac_bclk_o(o_bclk),
    .dac_ws_o(o_ws), .dac_mclk_o(o_mclk), .mute_status_o(o_stat));

  // ---------------- pin-level decoder ----------------
  logic prev_b = 1'b0, prev_m = 1'b0, prev_ws = 1'b0;
  int idx = 100, mrise = 0, last_ratio = 0, frames = 0, pad_bad = 0;
  logic [15:0] accl = '0, accr = '0, last_l = '0, last_r = '0;
  logic last_stat = 1'b0;

  always @(negedge clk) begin
    if (o_mclk && !prev_m) mrise = mrise + 1;
    if (o_bclk && !prev_b) begin
      last_ratio = mrise;
      mrise = 0;
      if (o_ws == !inv && prev_ws != !inv) idx = 0;
      else if (idx < 100) idx = idx + 1;
      if (idx >= 1 && idx <= 16) accl = {accl[14:0], o_sd};
      else if (idx >= 33 && idx <= 48) accr = {accr[14:0], o_sd};
      else if (idx < 64 && o_sd) pad_bad = pad_bad + 1;
      if (idx == 48) begin
        last_l = accl; last_r = accr; last_stat = o_stat; frames = frames + 1;
      end
      prev_ws = o_ws;
    end
    prev_b = o_bclk;
    prev_m = o_mclk;
  end

  // ---------------- helpers ----------------
  function automatic logic [15:0] scale(input logic [15:0] s, input int g);
    int p;
    p = $signed(s) * g;
    return 16'(p >>> GW);
  endfunction

  function automatic int find_gain(input logic [15:0] s, input logic [15:0] v);
    for (int k = 0; k <= NSTEP; k++)
      if (scale(s, k * STEP) == v) return k * STEP;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_frames(input int n);
    int target;
    target = frames + n;
    while (frames < target) @(negedge clk);
  endtask

  task automatic put_sample(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    pcm_l = l; pcm_r = r; pcm_v = 1'b1;
    @(negedge clk);
    pcm_v = 1'b0;
  endtask

  // ramp down (dir=0) or up (dir=1) with samples 7FFF / 8001
  task automatic check_ramp(input bit up, input string req);
    int g, prev, expg;
    prev = find_gain(16'h7FFF, last_l);
    for (int n = 0; n < NSTEP + 2; n++) begin
      wait_frames(1);
      g = find_gain(16'h7FFF, last_l);
      expg = up ? ((prev + STEP > FULL) ? FULL : prev + STEP)
                : ((prev - STEP < 0) ? 0 : prev - STEP);
      check(g == expg, req, g, expg);
      check(last_r == scale(16'h8001, g), "R9", last_r, scale(16'h8001, g));
      check(last_stat == (g < FULL), "R7", last_stat, g < FULL);
      prev = g;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", frames, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [15:0] rl, rr;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R4 reset state
    check({o_sd, o_bclk, o_ws, o_mclk, o_stat} == 5'b0, "R4", {o_sd, o_bclk, o_ws, o_mclk, o_stat}, 0);
    rst = 1'b0;

    // R10 basic pass-through, R1 padding, R3 default polarity
    put_sample(16'hA5C3, 16'h1234);
    wait_frames(3);
    check(last_l == 16'hA5C3, "R10", last_l, 16'hA5C3);
    check(last_r == 16'h1234, "R3", last_r, 16'h1234);
    check(last_stat == 1'b0, "R7", last_stat, 0);
    check(last_ratio == 4, "R2", last_ratio, 4);
    pad_bad = 0;
    wait_frames(2);
    check(pad_bad == 0, "R1", pad_bad, 0);

    // random patterns: sample, polarity, clock ratio
    for (int it = 0; it < 10; it++) begin
      rl = 16'($urandom); rr = 16'($urandom);
      @(negedge clk);
      inv = 1'($urandom); sel384 = 1'($urandom);
      put_sample(rl, rr);
      wait_frames(3);
      check(last_l == rl, "R10", last_l, rl);
      check(last_r == rr, "R3", last_r, rr);
      check(last_ratio == (sel384 ? 6 : 4), "R2", last_ratio, sel384 ? 6 : 4);
    end
    @(negedge clk); inv = 1'b0; sel384 = 1'b0;

    // R5 user mute ramp down and back up
    put_sample(16'h7FFF, 16'h8001);
    wait_frames(3);
    @(negedge clk); umute = 1'b1;
    wait_frames(2);
    check_ramp(1'b0, "R5");
    check(last_l == 16'h0000 && o_stat, "R5", last_l, 0);
    @(negedge clk); umute = 1'b0;
    wait_frames(2);
    check_ramp(1'b1, "R5");

    // R6 error ignored when disabled, mutes when enabled
    @(negedge clk); derr = 1'b1; emen = 1'b0;
    wait_frames(3);
    check(last_l == 16'h7FFF && !last_stat, "R6", last_l, 16'h7FFF);
    @(negedge clk); emen = 1'b1;
    wait_frames(NSTEP + 3);
    check(last_l == 16'h0000 && last_stat, "R6", last_l, 0);
    @(negedge clk); derr = 1'b0;
    wait_frames(NSTEP + 3);
    check(last_l == 16'h7FFF && !last_stat, "R6", last_l, 16'h7FFF);
    @(negedge clk); emen = 1'b0;

    // R8 bypass mode copies the external pins
    @(negedge clk); mode = 3'b110;
    for (int k = 0; k < 16; k++) begin
      bsd = 1'($urandom); bbclk = 1'($urandom); bws = 1'($urandom); bmclk = 1'($urandom);
      @(negedge clk);
      check({o_sd, o_bclk, o_ws, o_mclk} == {bsd, bbclk, bws, bmclk}, "R8",
            {o_sd, o_bclk, o_ws, o_mclk}, {bsd, bbclk, bws, bmclk});
    end
    // other mode code keeps internal output
    mode = 3'b010;
    put_sample(16'h0F0F, 16'hF00F);
    wait_frames(3);
    check(last_l == 16'h0F0F && last_r == 16'hF00F, "R8", last_l, 16'h0F0F);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule